// File: doc/BRIEF.md
# External-Bus Interrupt Status and Error Aggregator

This block collects the interrupt sources of an external-bus interface unit and drives one interrupt line. Two sources are completion pulses from the write and read DMA channels. They are captured into sticky bits. Two sources are FIFO service levels that follow their threshold comparisons directly. The fifth source is an error summary. It merges three conditions, and each condition has its own enable: a full write FIFO, a stalled read, and a transaction that waits on a not-ready signal for too long.

Software sees the block through a single-cycle register port. Writes take effect on the clock edge where `reg_wen` is high. Read data is combinational from `reg_addr`. The port has no handshake and never stalls. No streaming data passes through the block, so every pin is a plain control or status signal. The register word addresses are: 0 raw status, 1 mask, 2 masked status, 3 error status and clear, 4 configuration.

The configuration word is laid out as follows:
- bits 15:0 hold the maximum wait count.
- bit 16 enables the full-write-FIFO error.
- bit 17 enables the stalled-read error.
- bits 24:20 hold the write-FIFO trigger level.
- bits 29:25 hold the read-FIFO trigger level.

All other bits read as zero. This layout assumes the default widths.

Top module: `xbus_irq_agg`

## Requirements
- R1: The raw status word (address 0) carries write-DMA done in bit 4, read-DMA done in bit 3, write-FIFO service in bit 2, read-FIFO service in bit 1 and the error summary in bit 0. Bits 31:5 read as zero.
- R2: The mask register (address 1) stores bits 4:0 of a write, reads back with bits 31:5 zero, and changes only when it is written.
- R3: The masked status word (address 2) equals raw status AND mask. A write to address 2 changes nothing.
- R4: `irq` is high exactly when at least one masked status bit is set, in the same cycle.
- R5: A pulse on `wdma_done` or `rdma_done` sets raw bit 4 or bit 3 from the next cycle on. The bit stays set until a write to address 3 carries a 1 in bit 4 (write DMA) or bit 3 (read DMA).
- R6: Raw bit 2 is high in the same cycle whenever `wfifo_free` is less than or equal to the write trigger level (configuration bits 24:20).
- R7: Raw bit 1 is high in the same cycle whenever `rfifo_fill` is nonzero and at least the read trigger level (configuration bits 29:25).
- R8: While configuration bit 16 is set, each cycle with `wfifo_full` high sets error status bit 1 from the next cycle on. While bit 16 is clear, `wfifo_full` has no effect.
- R9: While configuration bit 17 is set, each cycle with `rd_stall` high sets error status bit 2 from the next cycle on. While bit 17 is clear, `rd_stall` has no effect.
- R10: A cycle is stalled when `xact_active` is high and `ext_ready` or `fifo_ready` is low. With a nonzero maximum wait N, the (N+1)th consecutive stalled cycle sets error status bit 0 from the next cycle on. A run reports only once. A run restarts after any unstalled cycle or any cycle with `xact_start` high, and such a cycle does not count. N = 0 disables the timeout.
- R11: Writing 1 to bit 2, 1 or 0 of address 3 clears only that error status bit. Raw bit 0 is the OR of error status bits 2:0.
- R12: When a set event and a clearing write meet on the same edge, the bit ends up set.
- R13: After reset the mask, configuration, error status and sticky DMA bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wdma_done | input | 1 | Write DMA completion pulse |
| rdma_done | input | 1 | Read DMA completion pulse |
| wfifo_free | input | CNT_W | Free entries in the write FIFO |
| rfifo_fill | input | CNT_W | Occupied entries in the read FIFO |
| wfifo_full | input | 1 | Write FIFO full |
| rd_stall | input | 1 | Read path stalled |
| xact_start | input | 1 | First cycle of a bus transaction |
| xact_active | input | 1 | A transaction is in progress |
| ext_ready | input | 1 | External device ready |
| fifo_ready | input | 1 | Internal FIFO ready |
| irq | output | 1 | Interrupt request |

## Verification
The FIFO service bits, the masked status word and `irq` follow their inputs in the same cycle. Sticky DMA bits, error status bits and register writes show up one edge after the stimulus. A timeout appears one edge after the (N+1)th stalled edge.

The bench drives inputs just after a rising edge. A behavioural reference model updates on that same edge. Read data and `irq` are compared at the falling edge, so a one-edge lag always lands between the drive and the comparison. Directed reads are placed at exact edge counts, one before and one at the timeout edge, to pin down the boundary.

// File: rtl/xbus_irq_pkg.sv
package xbus_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int NSRC   = 5;
  localparam int NERR   = 3;

  // source bit positions in the status and mask words
  localparam int SRC_ERR   = 0;
  localparam int SRC_RFIFO = 1;
  localparam int SRC_WFIFO = 2;
  localparam int SRC_RDMA  = 3;
  localparam int SRC_WDMA  = 4;

  // error status bit positions; DMA clear strobes share the clear word
  localparam int ERR_TMO    = 0;
  localparam int ERR_WFULL  = 1;
  localparam int ERR_RSTALL = 2;
  localparam int CLR_RDMA   = 3;
  localparam int CLR_WDMA   = 4;

  // configuration word field positions
  localparam int CFG_EN_WFULL  = 16;
  localparam int CFG_EN_RSTALL = 17;
  localparam int CFG_WTRIG_LSB = 20;

  typedef enum logic [ADDR_W-1:0] {
    RA_RAW   = 3'd0,
    RA_MASK  = 3'd1,
    RA_MSTAT = 3'd2,
    RA_ERR   = 3'd3,
    RA_CFG   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/xbus_cfg_regs.sv
module xbus_cfg_regs
  import xbus_irq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [NSRC-1:0]   raw_bits,
  input  logic [NERR-1:0]   err_bits,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NSRC-1:0]   mask_bits,
  output logic [WAIT_W-1:0] max_wait,
  output logic              en_wfull,
  output logic              en_rstall,
  output logic [CNT_W-1:0]  wr_trig,
  output logic [CNT_W-1:0]  rd_trig,
  output logic [NERR-1:0]   err_clr,
  output logic [1:0]        dma_clr
);
  localparam int RTRIG_LSB = CFG_WTRIG_LSB + CNT_W;

  reg_addr_e sel;
  logic      wr_mask, wr_cfg, wr_err;
  logic      unused_wbits;

  assign sel          = reg_addr_e'(reg_addr);
  assign wr_mask      = reg_wen && (sel == RA_MASK);
  assign wr_cfg       = reg_wen && (sel == RA_CFG);
  assign wr_err       = reg_wen && (sel == RA_ERR);
  assign unused_wbits = ^reg_wdata;

  assign err_clr = wr_err ? reg_wdata[NERR-1:0] : '0;
  assign dma_clr = wr_err ? {reg_wdata[CLR_WDMA], reg_wdata[CLR_RDMA]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_bits <= '0;
      max_wait  <= '0;
      en_wfull  <= 1'b0;
      en_rstall <= 1'b0;
      wr_trig   <= '0;
      rd_trig   <= '0;
    end else begin
      if (wr_mask) mask_bits <= reg_wdata[NSRC-1:0];
      if (wr_cfg) begin
        max_wait  <= reg_wdata[WAIT_W-1:0];
        en_wfull  <= reg_wdata[CFG_EN_WFULL];
        en_rstall <= reg_wdata[CFG_EN_RSTALL];
        wr_trig   <= reg_wdata[CFG_WTRIG_LSB +: CNT_W];
        rd_trig   <= reg_wdata[RTRIG_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      RA_RAW:   reg_rdata[NSRC-1:0] = raw_bits;
      RA_MASK:  reg_rdata[NSRC-1:0] = mask_bits;
      RA_MSTAT: reg_rdata[NSRC-1:0] = raw_bits & mask_bits;
      RA_ERR:   reg_rdata[NERR-1:0] = err_bits;
      RA_CFG: begin
        reg_rdata[WAIT_W-1:0]              = max_wait;
        reg_rdata[CFG_EN_WFULL]            = en_wfull;
        reg_rdata[CFG_EN_RSTALL]           = en_rstall;
        reg_rdata[CFG_WTRIG_LSB +: CNT_W]  = wr_trig;
        reg_rdata[RTRIG_LSB +: CNT_W]      = rd_trig;
      end
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xbus_src_capture.sv
module xbus_src_capture #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       dma_done,
  input  logic [1:0]       dma_clr,
  input  logic [CNT_W-1:0] wfifo_free,
  input  logic [CNT_W-1:0] rfifo_fill,
  input  logic [CNT_W-1:0] wr_trig,
  input  logic [CNT_W-1:0] rd_trig,
  output logic [1:0]       dma_bits,
  output logic             wr_svc,
  output logic             rd_svc
);
  localparam int NDMA = 2;

  // sticky completion flags; a set on the clearing edge wins
  for (genvar g = 0; g < NDMA; g++) begin : g_dma
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dma_bits[g] <= 1'b0;
      else        dma_bits[g] <= dma_done[g] | (dma_bits[g] & ~dma_clr[g]);
    end
  end

  assign wr_svc = (wfifo_free <= wr_trig);
  assign rd_svc = (rfifo_fill != '0) && (rfifo_fill >= rd_trig);
endmodule

// File: rtl/xbus_stall_timer.sv
module xbus_stall_timer #(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xact_start,
  input  logic              stalled,
  input  logic [WAIT_W-1:0] max_wait,
  output logic              to_evt
);
  logic [WAIT_W-1:0] cnt_q;
  logic              done_q;
  logic              restart;

  assign restart = xact_start || !stalled;
  assign to_evt  = !restart && (max_wait != '0) && !done_q && (cnt_q >= max_wait);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (restart) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (to_evt) done_q <= 1'b1;
      if (!done_q && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/xbus_err_track.sv
module xbus_err_track
  import xbus_irq_pkg::*;
#(
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfifo_full,
  input  logic              rd_stall,
  input  logic              en_wfull,
  input  logic              en_rstall,
  input  logic              xact_start,
  input  logic              xact_active,
  input  logic              ext_ready,
  input  logic              fifo_ready,
  input  logic [WAIT_W-1:0] max_wait,
  input  logic [NERR-1:0]   err_clr,
  output logic [NERR-1:0]   err_bits,
  output logic              err_any,
  output logic              to_evt
);
  logic            stalled;
  logic [NERR-1:0] err_set;

  assign stalled = xact_active && (!ext_ready || !fifo_ready);

  xbus_stall_timer #(.WAIT_W(WAIT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .xact_start (xact_start),
    .stalled    (stalled),
    .max_wait   (max_wait),
    .to_evt     (to_evt)
  );

  always_comb begin
    err_set             = '0;
    err_set[ERR_TMO]    = to_evt;
    err_set[ERR_WFULL]  = wfifo_full && en_wfull;
    err_set[ERR_RSTALL] = rd_stall && en_rstall;
  end

  for (genvar g = 0; g < NERR; g++) begin : g_err
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_bits[g] <= 1'b0;
      else        err_bits[g] <= err_set[g] | (err_bits[g] & ~err_clr[g]);
    end
  end

  assign err_any = |err_bits;
endmodule

// File: rtl/xbus_irq_agg.sv
module xbus_irq_agg
  import xbus_irq_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              wdma_done,
  input  logic              rdma_done,
  input  logic [CNT_W-1:0]  wfifo_free,
  input  logic [CNT_W-1:0]  rfifo_fill,
  input  logic              wfifo_full,
  input  logic              rd_stall,
  input  logic              xact_start,
  input  logic              xact_active,
  input  logic              ext_ready,
  input  logic              fifo_ready,
  output logic              irq
);
  logic [NSRC-1:0]   raw_w, mask_w;
  logic [NERR-1:0]   err_w, err_clr_w;
  logic [1:0]        dma_clr_w, dma_w;
  logic [WAIT_W-1:0] max_wait_w;
  logic [CNT_W-1:0]  wr_trig_w, rd_trig_w;
  logic              en_wfull_w, en_rstall_w;
  logic              wr_svc_w, rd_svc_w, err_any_w, to_evt_w;

  xbus_cfg_regs #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .raw_bits  (raw_w),
    .err_bits  (err_w),
    .reg_rdata (reg_rdata),
    .mask_bits (mask_w),
    .max_wait  (max_wait_w),
    .en_wfull  (en_wfull_w),
    .en_rstall (en_rstall_w),
    .wr_trig   (wr_trig_w),
    .rd_trig   (rd_trig_w),
    .err_clr   (err_clr_w),
    .dma_clr   (dma_clr_w)
  );

  xbus_src_capture #(.CNT_W(CNT_W)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_done   ({wdma_done, rdma_done}),
    .dma_clr    (dma_clr_w),
    .wfifo_free (wfifo_free),
    .rfifo_fill (rfifo_fill),
    .wr_trig    (wr_trig_w),
    .rd_trig    (rd_trig_w),
    .dma_bits   (dma_w),
    .wr_svc     (wr_svc_w),
    .rd_svc     (rd_svc_w)
  );

  xbus_err_track #(.WAIT_W(WAIT_W)) u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfifo_full  (wfifo_full),
    .rd_stall    (rd_stall),
    .en_wfull    (en_wfull_w),
    .en_rstall   (en_rstall_w),
    .xact_start  (xact_start),
    .xact_active (xact_active),
    .ext_ready   (ext_ready),
    .fifo_ready  (fifo_ready),
    .max_wait    (max_wait_w),
    .err_clr     (err_clr_w),
    .err_bits    (err_w),
    .err_any     (err_any_w),
    .to_evt      (to_evt_w)
  );

  always_comb begin
    raw_w            = '0;
    raw_w[SRC_WDMA]  = dma_w[1];
    raw_w[SRC_RDMA]  = dma_w[0];
    raw_w[SRC_WFIFO] = wr_svc_w;
    raw_w[SRC_RFIFO] = rd_svc_w;
    raw_w[SRC_ERR]   = err_any_w;
  end

  assign irq = |(raw_w & mask_w);
endmodule

// File: rtl/xbus_irq_chk.sv
module xbus_irq_chk
  import xbus_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wen,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              wdma_done,
  input logic              irq,
  input logic [NSRC-1:0]   raw_bits,
  input logic [NSRC-1:0]   mask_bits,
  input logic [NERR-1:0]   err_bits,
  input logic              to_evt
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr <= ADDR_W'(RA_MSTAT)) |-> (reg_rdata[REG_W-1:NSRC] == '0)); // R1

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wen && reg_addr == ADDR_W'(RA_MASK)) |=> $stable(mask_bits)); // R2

  AST_MSTAT_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(RA_MSTAT)) |-> (reg_rdata[NSRC-1:0] == (raw_bits & mask_bits))); // R3

  AST_IRQ_MSTAT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(RA_MSTAT)) |-> (irq == (|reg_rdata))); // R4

  AST_WDMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_bits[SRC_WDMA] && !(reg_wen && reg_addr == ADDR_W'(RA_ERR) && reg_wdata[CLR_WDMA]))
    |=> raw_bits[SRC_WDMA]); // R5

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |=> !to_evt); // R10

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    raw_bits[SRC_ERR] == (|err_bits)); // R11

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdma_done |=> raw_bits[SRC_WDMA]); // R12
endmodule

bind xbus_irq_agg xbus_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wen   (reg_wen),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .wdma_done (wdma_done),
  .irq       (irq),
  .raw_bits  (raw_w),
  .mask_bits (mask_w),
  .err_bits  (err_w),
  .to_evt    (to_evt_w)
);

// File: tb/sim_xbus_irq_agg.sv
`timescale 1ns/1ps
module sim_xbus_irq_agg;
  localparam int CNT_W = 5;
  localparam logic [31:0] CFG_KEEP = 32'h3FF3_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wdma_done = 0, rdma_done = 0, wfifo_full = 0, rd_stall = 0;
  logic        xact_start = 0, xact_active = 0, ext_ready = 1, fifo_ready = 1;
  logic [CNT_W-1:0] wfifo_free = 5'd16, rfifo_fill = 5'd0;
  logic        irq;

  int total = 0, bad = 0;
  bit cmp_en = 0, finished = 0;

  // reference model state
  bit     m_wdma = 0, m_rdma = 0;
  bit [2:0]  m_err = '0;
  bit [4:0]  m_mask = '0;
  bit [31:0] m_cfg = '0;
  int     run = 0;
  bit     fired = 0;

  always #5 clk = ~clk;

  xbus_irq_agg #(.CNT_W(CNT_W), .WAIT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdma_done(wdma_done),
    .rdma_done(rdma_done), .wfifo_free(wfifo_free), .rfifo_fill(rfifo_fill),
    .wfifo_full(wfifo_full), .rd_stall(rd_stall), .xact_start(xact_start),
    .xact_active(xact_active), .ext_ready(ext_ready), .fifo_ready(fifo_ready),
    .irq(irq)
  );

  function automatic bit [4:0] m_raw();
    int mw_trig = int'(m_cfg[24:20]);
    int mr_trig = int'(m_cfg[29:25]);
    bit ws = int'(wfifo_free) <= mw_trig;
    bit rs = (rfifo_fill != 0) && (int'(rfifo_fill) >= mr_trig);
    return {m_wdma, m_rdma, ws, rs, |m_err};
  endfunction

  function automatic bit [31:0] m_read(input bit [2:0] a);
    case (a)
      3'd0: return {27'b0, m_raw()};
      3'd1: return {27'b0, m_mask};
      3'd2: return {27'b0, m_raw() & m_mask};
      3'd3: return {29'b0, m_err};
      3'd4: return m_cfg;
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // model advances on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_wdma = 0; m_rdma = 0; m_err = '0; m_mask = '0; m_cfg = '0; run = 0; fired = 0;
    end else begin
      bit stall, tmo, clr_w;
      int mw;
      bit [31:0] wd;
      wd    = reg_wdata;
      clr_w = reg_wen && reg_addr == 3'd3;
      mw    = int'(m_cfg[15:0]);
      stall = xact_active && (!ext_ready || !fifo_ready);
      tmo   = 0;
      if (xact_start || !stall) begin run = 0; fired = 0; end
      else begin
        run++;
        if (mw != 0 && !fired && run >= mw + 1) begin tmo = 1; fired = 1; end
      end
      if (clr_w) m_err = m_err & ~wd[2:0];
      if (tmo) m_err[0] = 1;
      if (wfifo_full && m_cfg[16]) m_err[1] = 1;
      if (rd_stall && m_cfg[17]) m_err[2] = 1;
      if (clr_w && wd[4]) m_wdma = 0;
      if (clr_w && wd[3]) m_rdma = 0;
      if (wdma_done) m_wdma = 1;
      if (rdma_done) m_rdma = 1;
      if (reg_wen && reg_addr == 3'd1) m_mask = wd[4:0];
      if (reg_wen && reg_addr == 3'd4) m_cfg = wd & CFG_KEEP;
    end
  end

  // every-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      logic [31:0] e;
      e = m_read(reg_addr);
      case (reg_addr)
        3'd0: chk(reg_rdata === e, "R1 raw model", reg_rdata, e);
        3'd1: chk(reg_rdata === e, "R2 mask model", reg_rdata, e);
        3'd2: chk(reg_rdata === e, "R3 masked model", reg_rdata, e);
        3'd3: chk(reg_rdata === e, "R11 err model", reg_rdata, e);
        default: chk(reg_rdata === e, "R13 cfg model", reg_rdata, e);
      endcase
      chk(irq === |(m_raw() & m_mask), "R4 irq model", {31'b0, irq}, {31'b0, |(m_raw() & m_mask)});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    step(1);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    cmp_en = 1;
    // R13 reset state
    for (int a = 0; a < 5; a++) rd(3'(a), 32'h0, "R13 reset");
    chk(irq === 1'b0, "R13 irq reset", {31'b0, irq}, 32'h0);

    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h1F, "R2 mask readback");

    // R5 sticky DMA
    wdma_done = 1; step(1); wdma_done = 0;
    rd(3'd0, 32'h10, "R5 wdma set");
    chk(irq === 1'b1, "R4 irq on", {31'b0, irq}, 32'h1);
    step(5);
    rd(3'd0, 32'h10, "R5 wdma sticky");
    wr(3'd3, 32'h08);
    rd(3'd0, 32'h10, "R5 other clear");
    wr(3'd3, 32'h10);
    rd(3'd0, 32'h00, "R5 wdma cleared");

    // R3 masked status read-only and masking
    wr(3'd2, 32'h1F);
    rd(3'd2, 32'h00, "R3 write ignored");
    rdma_done = 1; step(1); rdma_done = 0;
    rd(3'd2, 32'h08, "R3 masked rdma");
    wr(3'd1, 32'h0);
    rd(3'd2, 32'h00, "R3 masked off");
    rd(3'd0, 32'h08, "R1 raw under mask");
    chk(irq === 1'b0, "R4 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h1F);

    // R12 set wins over clear
    reg_addr = 3'd3; reg_wdata = 32'h08; reg_wen = 1; rdma_done = 1;
    step(1);
    reg_wen = 0; rdma_done = 0;
    rd(3'd0, 32'h08, "R12 set wins");
    wr(3'd3, 32'h08);
    rd(3'd0, 32'h00, "R12 later clear");

    // R6 write FIFO level
    wr(3'd4, 32'd4 << 20);
    wfifo_free = 5'd5; rd(3'd0, 32'h00, "R6 above level");
    step(1); wfifo_free = 5'd4; rd(3'd0, 32'h04, "R6 at level");
    step(1); wfifo_free = 5'd0; rd(3'd0, 32'h04, "R6 empty");
    step(1); wfifo_free = 5'd16; rd(3'd0, 32'h00, "R6 released");

    // R7 read FIFO level
    wr(3'd4, 32'd3 << 25);
    rfifo_fill = 5'd2; rd(3'd0, 32'h00, "R7 below");
    step(1); rfifo_fill = 5'd3; rd(3'd0, 32'h02, "R7 at level");
    step(1); rfifo_fill = 5'd16; rd(3'd0, 32'h02, "R7 full");
    wr(3'd4, 32'h0);
    rfifo_fill = 5'd0; rd(3'd0, 32'h00, "R7 zero fill");
    step(1); rfifo_fill = 5'd1; rd(3'd0, 32'h02, "R7 one entry");
    step(1); rfifo_fill = 5'd0;

    // R8 full write FIFO
    wfifo_full = 1; step(2);
    rd(3'd3, 32'h0, "R8 disabled");
    wr(3'd4, 32'h1 << 16);
    step(1);
    rd(3'd3, 32'h2, "R8 enabled");
    rd(3'd0, 32'h01, "R11 summary set");
    wfifo_full = 0;
    wr(3'd3, 32'h2);
    rd(3'd3, 32'h0, "R11 w1c");

    // R9 stalled read
    wr(3'd4, 32'h0);
    rd_stall = 1; step(2); rd_stall = 0;
    rd(3'd3, 32'h0, "R9 disabled");
    wr(3'd4, 32'h1 << 17);
    rd_stall = 1; step(1); rd_stall = 0;
    rd(3'd3, 32'h4, "R9 enabled");
    wr(3'd3, 32'h4);

    // R11 per-bit clear
    wr(3'd4, 32'h3 << 16);
    wfifo_full = 1; rd_stall = 1; step(1); wfifo_full = 0; rd_stall = 0;
    rd(3'd3, 32'h6, "R11 both set");
    wr(3'd3, 32'h2);
    rd(3'd3, 32'h4, "R11 one cleared");
    rd(3'd0, 32'h01, "R11 summary held");
    wr(3'd3, 32'h4);
    rd(3'd0, 32'h00, "R11 summary clear");

    // R10 timeout, limit 3
    wr(3'd4, 32'd3);
    xact_active = 1; ext_ready = 0;
    step(3);
    rd(3'd3, 32'h0, "R10 before limit");
    step(1);
    rd(3'd3, 32'h1, "R10 at limit");
    chk(irq === 1'b1, "R4 irq on error", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h1);
    step(5);
    rd(3'd3, 32'h0, "R10 single report");
    ext_ready = 1; step(1); ext_ready = 0;
    step(3); rd(3'd3, 32'h0, "R10 restart early");
    step(1); rd(3'd3, 32'h1, "R10 restart fire");
    wr(3'd3, 32'h1);
    xact_start = 1; step(1); xact_start = 0;
    step(3); rd(3'd3, 32'h0, "R10 new xact early");
    step(1); rd(3'd3, 32'h1, "R10 new xact fire");
    wr(3'd3, 32'h1);
    xact_active = 0; ext_ready = 1; step(1);
    xact_active = 1; fifo_ready = 0;
    step(4); rd(3'd3, 32'h1, "R10 fifo not ready");
    wr(3'd3, 32'h1);
    wr(3'd4, 32'd0);
    xact_active = 0; step(1); xact_active = 1;
    step(30); rd(3'd3, 32'h0, "R10 zero disables");
    xact_active = 0; fifo_ready = 1;
    step(3);
    finish_run();
  end
endmodule